// File: doc/BRIEF.md
# 1-Wire Slave ROM Command Layer

This block is the network-layer controller of a 1-Wire slave device. A bit-level engine below it reports bus resets, with a flag for long resets. It also delivers each bit the master writes, and it strobes the end of each read slot. The controller shows the bit the slave should answer with on the next read slot. It decodes the ROM function byte that follows every bus reset. It compares or sends the slave's 64-bit identity code, and it raises a grant line to the memory-function layer once the slave has been addressed.

Two flags live in the block and steer the protocol. A resume flag is set when an addressing step completes that selects this slave alone. While it is set, the slave can be selected again later by a one-byte command, without its code. An overdrive flag tells the bit engine to use fast timing. Several commands set it. Only a long bus reset clears it.

Search ROM is handled as a plain per-bit triplet: true bit, complement bit, then the master's chosen direction. CRC generation and the memory commands belong to other blocks.

Top module: `owrom_net_layer`

## Requirements
- R1: After the synchronous reset `rst`, the outputs are `grant`=0, `od_mode`=0 and `tx_bit`=1. The slave ignores written bits until the first bus reset.
- R2: After each bus reset, the next 8 written bits form the command byte, least-significant bit first. Skip (CCh) raises `grant` in the cycle after the 8th bit is taken, and not before.
- R3: Match (55h) is followed by 64 code bits, LSB first. If all 64 bits equal the identity code, `grant` rises and the resume flag is set. At the first bit that differs, the slave goes idle (no grant) and the resume flag is cleared.
- R4: Resume (A5h) raises `grant` only if the resume flag is set. Otherwise the slave stays idle with `grant`=0 until the next bus reset.
- R5: Overdrive-Skip (3Ch) sets `od_mode`=1 and raises `grant` with no code comparison. It leaves the resume flag unchanged.
- R6: Overdrive-Match (69h) sets `od_mode`=1 once the command byte is taken, then compares 64 code bits as in R3. An exact match grants and sets the resume flag. A mismatch leaves the slave idle and clears the resume flag, while `od_mode` stays 1.
- R7: Any bus reset (`bus_rst_valid`=1) aborts the command in progress, drops `grant` and restarts command collection. If `bus_rst_long`=1, `od_mode` is cleared; otherwise it is kept. The resume flag survives both kinds of reset.
- R8: During Read ROM (33h), `tx_bit` shows identity bit i, starting at i=0, and moves to the next bit on each `rd_slot`. After the 64th `rd_slot`, `grant` rises. The resume flag is unchanged.
- R9: During Search ROM (F0h), for each bit i the sequence is as follows. `tx_bit` shows code bit i. After one `rd_slot` it shows the complement of that bit. After a second `rd_slot` the slave waits for one written bit. If that bit equals code bit i, the slave moves on to bit i+1. Otherwise it goes idle and clears the resume flag. Passing all 64 bits raises `grant` and sets the resume flag.
- R10: Any other command byte (for example 00h) leaves the slave idle with `grant`=0 and `tx_bit`=1 until the next bus reset.
- R11: While granted or idle, written bits and `rd_slot` strobes change neither `grant` nor `od_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst_valid | input | 1 | One-cycle strobe: bit engine saw a bus reset |
| bus_rst_long | input | 1 | Qualifies the strobe: reset was long enough to leave overdrive |
| rx_valid | input | 1 | One-cycle strobe: a written bit is available |
| rx_bit | input | 1 | Value of the written bit |
| rd_slot | input | 1 | One-cycle strobe: a read slot has completed |
| tx_bit | output | 1 | Bit to answer with on the next read slot (1 = release line) |
| grant | output | 1 | Memory-function layer owns the bus |
| od_mode | output | 1 | Overdrive timing selected |

## Verification
The bench checks that a single wrong code bit, placed deep in the code, ends a Match. A design that compared only part of the code would still grant there. It also checks the resume flag's lifetime across resets of both lengths and across failed Match, Overdrive-Match and Search attempts. A design that cleared the flag on reset, or kept it after a mismatch, would answer Resume wrongly. A short reset after Overdrive-Skip must keep `od_mode`, and a long one must clear it. A reset in the middle of a command byte must not leave stale bits in the shifter, or the next Skip would not decode. The Read ROM and Search ROM walks are compared bit by bit. This catches a slave that sends its code in MSB-first order or leaves out the complement phase.

// File: rtl/owrom_pkg.sv
package owrom_pkg;

    localparam int CMD_W = 8;

    typedef enum logic [7:0] {
        CMD_READ     = 8'h33,
        CMD_SKIP     = 8'hCC,
        CMD_MATCH    = 8'h55,
        CMD_SEARCH   = 8'hF0,
        CMD_RESUME   = 8'hA5,
        CMD_OD_SKIP  = 8'h3C,
        CMD_OD_MATCH = 8'h69
    } rom_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_MATCH,
        ST_READ,
        ST_SRCH,
        ST_GRANT
    } net_state_e;

    typedef enum logic [1:0] {
        PH_TRUE,
        PH_COMP,
        PH_DIR
    } srch_phase_e;

    typedef struct packed {
        logic set_rc;
        logic clr_rc;
        logic set_od;
    } flag_req_t;

    typedef struct packed {
        net_state_e state;
        logic       set_od;
    } cmd_route_t;

    function automatic cmd_route_t route_cmd(input logic [CMD_W-1:0] cmd,
                                             input logic rc);
        cmd_route_t r;
        r.state  = ST_IDLE;
        r.set_od = 1'b0;
        case (cmd)
            CMD_SKIP:     r.state = ST_GRANT;
            CMD_MATCH:    r.state = ST_MATCH;
            CMD_READ:     r.state = ST_READ;
            CMD_SEARCH:   r.state = ST_SRCH;
            CMD_RESUME:   r.state = rc ? ST_GRANT : ST_IDLE;
            CMD_OD_SKIP:  begin r.state = ST_GRANT; r.set_od = 1'b1; end
            CMD_OD_MATCH: begin r.state = ST_MATCH; r.set_od = 1'b1; end
            default:      r.state = ST_IDLE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/owrom_cmd_shift.sv
module owrom_cmd_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic         done,
    output logic [W-1:0] value
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]     sreg_q;
    logic [CNT_W-1:0] cnt_q;

    assign done  = shift_en && (cnt_q == CNT_W'(W - 1));
    assign value = {bit_in, sreg_q[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (shift_en) begin
            sreg_q <= value;
            cnt_q  <= done ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/owrom_id_walker.sv
module owrom_id_walker #(
    parameter int          ID_W = 64,
    parameter logic [63:0] ID   = 64'h0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    step,
    output logic                    cur_bit,
    output logic                    last,
    output logic [$clog2(ID_W)-1:0] idx
);
    localparam int IDX_W = $clog2(ID_W);

    logic [ID_W-1:0] code;
    assign code = ID[ID_W-1:0];

    logic [IDX_W-1:0] idx_q;

    assign idx     = idx_q;
    assign cur_bit = code[idx_q];
    assign last    = (idx_q == IDX_W'(ID_W - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx_q <= '0;
        end else if (step && !last) begin
            idx_q <= idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/owrom_flags.sv
module owrom_flags
    import owrom_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      long_rst,
    input  flag_req_t req,
    output logic      rc,
    output logic      od
);
    logic rc_q, od_q;

    assign rc = rc_q;
    assign od = od_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rc_q <= 1'b0;
            od_q <= 1'b0;
        end else begin
            if (req.clr_rc)      rc_q <= 1'b0;
            else if (req.set_rc) rc_q <= 1'b1;
            if (long_rst)        od_q <= 1'b0;
            else if (req.set_od) od_q <= 1'b1;
        end
    end

    // R3 / R6 / R9: a failed comparison leaves the resume flag clear
    p_rc_cleared_r3: assert property (@(posedge clk) disable iff (rst)
        req.clr_rc |=> !rc_q);

    // R7: a long bus reset drops overdrive
    p_od_long_reset_r7: assert property (@(posedge clk) disable iff (rst)
        long_rst |=> !od_q);

    // R6: overdrive is sticky apart from a long reset
    p_od_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        od_q && !long_rst |=> od_q);

endmodule

// File: rtl/owrom_net_layer.sv
module owrom_net_layer
    import owrom_pkg::*;
#(
    parameter int          ID_W = 64,
    parameter logic [63:0] ID   = 64'h5A3C_0F1E_7B29_4D01
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_rst_valid,
    input  logic bus_rst_long,
    input  logic rx_valid,
    input  logic rx_bit,
    input  logic rd_slot,
    output logic tx_bit,
    output logic grant,
    output logic od_mode
);
    localparam int IDX_W = $clog2(ID_W);

    net_state_e  state_q, state_d;
    srch_phase_e phase_q, phase_d;
    flag_req_t   freq;
    cmd_route_t  route;

    logic             byte_done;
    logic [CMD_W-1:0] byte_val;
    logic             shift_en;
    logic             id_bit, id_last, walk_step, walk_clear;
    logic [IDX_W-1:0] id_idx;
    logic             rc, od;

    assign shift_en   = rx_valid && !bus_rst_valid && (state_q == ST_CMD);
    assign walk_clear = bus_rst_valid || (state_q == ST_CMD);

    owrom_cmd_shift #(.W(CMD_W)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .clear    (bus_rst_valid),
        .shift_en (shift_en),
        .bit_in   (rx_bit),
        .done     (byte_done),
        .value    (byte_val)
    );

    owrom_id_walker #(.ID_W(ID_W), .ID(ID)) u_walk (
        .clk     (clk),
        .rst     (rst),
        .clear   (walk_clear),
        .step    (walk_step),
        .cur_bit (id_bit),
        .last    (id_last),
        .idx     (id_idx)
    );

    owrom_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .long_rst (bus_rst_valid && bus_rst_long),
        .req      (freq),
        .rc       (rc),
        .od       (od)
    );

    assign route = route_cmd(byte_val, rc);

    always_comb begin
        state_d   = state_q;
        phase_d   = phase_q;
        freq      = '0;
        walk_step = 1'b0;
        if (bus_rst_valid) begin
            state_d = ST_CMD;
            phase_d = PH_TRUE;
        end else begin
            case (state_q)
                ST_CMD: begin
                    if (byte_done) begin
                        state_d     = route.state;
                        freq.set_od = route.set_od;
                        phase_d     = PH_TRUE;
                    end
                end
                ST_MATCH: begin
                    if (rx_valid) begin
                        if (rx_bit != id_bit) begin
                            freq.clr_rc = 1'b1;
                            state_d     = ST_IDLE;
                        end else if (id_last) begin
                            freq.set_rc = 1'b1;
                            state_d     = ST_GRANT;
                        end else begin
                            walk_step = 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (rd_slot) begin
                        if (id_last) state_d = ST_GRANT;
                        else         walk_step = 1'b1;
                    end
                end
                ST_SRCH: begin
                    case (phase_q)
                        PH_TRUE: if (rd_slot) phase_d = PH_COMP;
                        PH_COMP: if (rd_slot) phase_d = PH_DIR;
                        default: begin
                            if (rx_valid) begin
                                if (rx_bit != id_bit) begin
                                    freq.clr_rc = 1'b1;
                                    state_d     = ST_IDLE;
                                end else if (id_last) begin
                                    freq.set_rc = 1'b1;
                                    state_d     = ST_GRANT;
                                end else begin
                                    walk_step = 1'b1;
                                    phase_d   = PH_TRUE;
                                end
                            end
                        end
                    endcase
                end
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= PH_TRUE;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    always_comb begin
        tx_bit = 1'b1;
        if (state_q == ST_READ) begin
            tx_bit = id_bit;
        end else if (state_q == ST_SRCH) begin
            if (phase_q == PH_TRUE)      tx_bit = id_bit;
            else if (phase_q == PH_COMP) tx_bit = ~id_bit;
        end
    end

    assign grant   = (state_q == ST_GRANT);
    assign od_mode = od;

    // R7: every bus reset takes the bus back from the memory layer
    p_reset_drops_grant_r7: assert property (@(posedge clk) disable iff (rst)
        bus_rst_valid |=> !grant);

    // R4: Resume without the flag never grants
    p_resume_gate_r4: assert property (@(posedge clk) disable iff (rst)
        byte_done && (byte_val == CMD_RESUME) && !rc |=> !grant);

    // R11: grant is held until the next bus reset
    p_grant_hold_r11: assert property (@(posedge clk) disable iff (rst)
        grant && !bus_rst_valid |=> grant);

    // R10: an idle slave stays silent until a bus reset
    p_idle_silent_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) && !bus_rst_valid |=> !grant && tx_bit);

    // R2: the command byte completes only from the collection state
    p_byte_in_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> (id_idx == '0));

endmodule

// File: tb/test_owrom_net_layer.sv
module test_owrom_net_layer;

    localparam logic [63:0] ID = 64'h8E3C_A51F_7B29_4D61;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_rst_valid = 1'b0, bus_rst_long = 1'b0;
    logic rx_valid = 1'b0, rx_bit = 1'b0, rd_slot = 1'b0;
    logic tx_bit, grant, od_mode;

    always #5 clk = ~clk;

    owrom_net_layer #(.ID_W(64), .ID(ID)) i_owrom_net_layer (
        .clk(clk), .rst(rst),
        .bus_rst_valid(bus_rst_valid), .bus_rst_long(bus_rst_long),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .rd_slot(rd_slot),
        .tx_bit(tx_bit), .grant(grant), .od_mode(od_mode)
    );

    typedef struct {
        string tag;
        logic  g;
        logic  o;
        logic  t;
        bit    ct;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   finished = 0;

    // monitor: pops expectations and compares them with the ports
    always @(negedge clk) begin
        #1;
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (grant !== e.g || od_mode !== e.o || (e.ct && tx_bit !== e.t)) begin
                n_fail++;
                $display("FAIL %s: grant=%b od=%b tx=%b expected grant=%b od=%b tx=%b",
                         e.tag, grant, od_mode, tx_bit, e.g, e.o, e.t);
            end
        end
    end

    task automatic expect_out(input string tag, input logic g, input logic o,
                              input logic t, input bit ct);
        exp_t e;
        e.tag = tag; e.g = g; e.o = o; e.t = t; e.ct = ct;
        exp_q.push_back(e);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); rx_valid = 1'b1; rx_bit = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic send_code(input logic [63:0] c);
        for (int i = 0; i < 64; i++) send_bit(c[i]);
    endtask

    task automatic bus_reset(input logic lng);
        @(negedge clk); bus_rst_valid = 1'b1; bus_rst_long = lng;
        @(negedge clk); bus_rst_valid = 1'b0; bus_rst_long = 1'b0;
    endtask

    task automatic read_slot();
        @(negedge clk); rd_slot = 1'b1;
        @(negedge clk); rd_slot = 1'b0;
    endtask

    task automatic try_resume(input string tag, input logic g, input logic o);
        bus_reset(1'b0);
        send_byte(8'hA5);
        expect_out(tag, g, o, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_out("R1 reset state", 1'b0, 1'b0, 1'b1, 1'b1);
        send_byte(8'hCC);
        expect_out("R1 ignored before bus reset", 1'b0, 1'b0, 1'b1, 1'b1);

        // Skip
        bus_reset(1'b0);
        for (int i = 0; i < 7; i++) send_bit(1'(8'hCC >> i));
        expect_out("R2 no grant after 7 bits", 1'b0, 1'b0, 1'b1, 1'b1);
        send_bit(1'b1);
        expect_out("R2 skip grants", 1'b1, 1'b0, 1'b1, 1'b1);
        send_byte(8'h00);
        read_slot();
        expect_out("R11 grant held", 1'b1, 1'b0, 1'b1, 1'b1);

        // Resume without flag, then match
        try_resume("R4 resume without flag", 1'b0, 1'b0);
        send_byte(8'hCC);
        expect_out("R11 idle ignores bits", 1'b0, 1'b0, 1'b1, 1'b1);
        bus_reset(1'b0);
        send_byte(8'h55);
        send_code(ID);
        expect_out("R3 exact match grants", 1'b1, 1'b0, 1'b1, 1'b1);
        bus_reset(1'b0);
        expect_out("R7 bus reset drops grant", 1'b0, 1'b0, 1'b1, 1'b1);
        send_byte(8'hA5);
        expect_out("R4 resume with flag", 1'b1, 1'b0, 1'b1, 1'b1);

        // mismatch deep in the code
        bus_reset(1'b0);
        send_byte(8'h55);
        send_code(ID ^ (64'h1 << 40));
        expect_out("R3 mismatch bit 40 no grant", 1'b0, 1'b0, 1'b1, 1'b1);
        try_resume("R3 mismatch cleared flag", 1'b0, 1'b0);

        // overdrive skip and short/long resets
        bus_reset(1'b0);
        send_byte(8'h3C);
        expect_out("R5 od skip grants", 1'b1, 1'b1, 1'b1, 1'b1);
        try_resume("R5 od skip leaves flag clear", 1'b0, 1'b1);
        bus_reset(1'b0);
        expect_out("R7 short reset keeps od", 1'b0, 1'b1, 1'b1, 1'b1);
        send_byte(8'h69);
        send_code(ID);
        expect_out("R6 od match grants", 1'b1, 1'b1, 1'b1, 1'b1);
        bus_reset(1'b1);
        expect_out("R7 long reset clears od", 1'b0, 1'b0, 1'b1, 1'b1);
        send_byte(8'hA5);
        expect_out("R7 flag survives long reset", 1'b1, 1'b0, 1'b1, 1'b1);

        // od match mismatch
        bus_reset(1'b1);
        send_byte(8'h69);
        expect_out("R6 od set at command", 1'b0, 1'b1, 1'b1, 1'b1);
        send_code(ID ^ 64'h8000_0000_0000_0000);
        expect_out("R6 od mismatch no grant", 1'b0, 1'b1, 1'b1, 1'b1);
        try_resume("R6 od mismatch cleared flag", 1'b0, 1'b1);

        // Read ROM
        bus_reset(1'b1);
        send_byte(8'h33);
        for (int i = 0; i < 64; i++) begin
            expect_out("R8 read bit", 1'b0, 1'b0, ID[i], 1'b1);
            read_slot();
        end
        expect_out("R8 read grants", 1'b1, 1'b0, 1'b1, 1'b1);
        try_resume("R8 read leaves flag clear", 1'b0, 1'b0);

        // Search ROM full pass
        bus_reset(1'b0);
        send_byte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            expect_out("R9 search true bit", 1'b0, 1'b0, ID[i], 1'b1);
            read_slot();
            expect_out("R9 search complement", 1'b0, 1'b0, ~ID[i], 1'b1);
            read_slot();
            send_bit(ID[i]);
        end
        expect_out("R9 search grants", 1'b1, 1'b0, 1'b1, 1'b1);
        try_resume("R9 search sets flag", 1'b1, 1'b0);

        // Search ROM losing at bit 5
        bus_reset(1'b0);
        send_byte(8'hF0);
        for (int i = 0; i < 6; i++) begin
            read_slot();
            read_slot();
            send_bit(i == 5 ? ~ID[i] : ID[i]);
        end
        expect_out("R9 search drop out", 1'b0, 1'b0, 1'b1, 1'b1);
        read_slot();
        expect_out("R11 idle ignores read slots", 1'b0, 1'b0, 1'b1, 1'b1);
        try_resume("R9 search loss cleared flag", 1'b0, 1'b0);

        // unknown command
        bus_reset(1'b0);
        send_byte(8'h00);
        expect_out("R10 unknown command idle", 1'b0, 1'b0, 1'b1, 1'b1);
        send_byte(8'hCC);
        expect_out("R10 stays idle", 1'b0, 1'b0, 1'b1, 1'b1);

        // abort mid-byte
        bus_reset(1'b0);
        for (int i = 0; i < 4; i++) send_bit(1'(8'h55 >> i));
        bus_reset(1'b0);
        send_byte(8'hCC);
        expect_out("R7 abort mid byte then skip", 1'b1, 1'b0, 1'b1, 1'b1);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (R1-sequence): actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule